// File: doc/BRIEF.md
# Data Cache Front End with Address-Bit Bypass

This block sits between a 32-bit processor load/store port and a single-word memory bus. Each access is sorted in the cycle it is accepted. An access goes around the cache when its top address bit is set or when it is tagged as an I/O access. Every other access is served by a direct-mapped, write-back, write-allocate line store of 64 lines of 32 bytes each. The top address bit never reaches the bus, so the lower and upper halves of the 4 GB processor space reach the same 2 GB of physical storage.

The cache keeps no coherence between the two aliases of a location. Software can issue a flush command for an address. The flush writes the matching line back if it is dirty and then invalidates it, which lets a cached view and an uncached view of the same data agree again. Requests are taken one at a time. The processor holds a request until a one-cycle done pulse, and a busy flag covers the whole time between acceptance and completion.

Top module: `dc_front`

## Requirements
- R1: An access with cpu_addr[31]=1 (and cpu_flush=0) makes exactly one bus transfer and never fills a line: a later cached read of the same line still misses and makes 8 bus reads.
- R2: An access with cpu_io=1 bypasses the cache whatever cpu_addr[31] is. An I/O read returns the bus word even when a dirty cached copy of that word exists.
- R3: mem_addr carries cpu_addr[30:2] with bits [1:0] zero and no bit 31. Addresses A and A|0x80000000 reach the same memory word.
- R4: An uncached access raises mem_req in the first cycle after the edge that accepts it, with no tag lookup cycle in between.
- R5: The cache is direct-mapped with index cpu_addr[10:5], word select cpu_addr[4:2] and tag cpu_addr[30:11]. A read or write hit makes no bus transfer.
- R6: A miss allocates the line for both reads and writes. When the victim is valid and dirty, its 8 words are written to the bus before any of the 8 refill reads.
- R7: A flush (cpu_flush=1) of a valid dirty line whose tag matches makes 8 bus writes and invalidates the line. A flush of an absent line makes no bus transfer. A later read of a flushed line misses.
- R8: A cached write is not visible through the uncached alias until the line is flushed or evicted.
- R9: Writes honour cpu_be (bit n enables byte lane n, bits 8n+7:8n). An uncached write is one bus write that carries the same byte enables.
- R10: Only one request is accepted at a time. cpu_busy is high from the cycle after acceptance until and including the single cycle in which cpu_done pulses. A pending bus request holds its address steady until mem_ready.
- R11: Reset clears all valid and dirty state and leaves cpu_busy, cpu_done and mem_req low. Dirty data held at reset is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Request, held until cpu_done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_io | input | 1 | I/O access, always uncached |
| cpu_flush | input | 1 | Flush the line holding cpu_addr |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_rdata | output | 32 | Read data, valid with cpu_done |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_busy | output | 1 | Request in progress |
| mem_req | output | 1 | Bus request, held until mem_ready |
| mem_we | output | 1 | Bus write |
| mem_addr | output | 31 | Word-aligned physical byte address |
| mem_wdata | output | 32 | Bus write data |
| mem_be | output | 4 | Bus byte enables |
| mem_rdata | input | 32 | Bus read data, valid with mem_ready |
| mem_ready | input | 1 | Bus transfer complete |

## Verification
The assertions assume that the processor raises cpu_req only while cpu_busy is low, and not in the two cycles after reset release while the internal reset is still held. They also assume that the request fields stay stable until cpu_done. The bench drives each request on a falling edge and keeps it until it has seen cpu_done. It raises the next request no earlier than the falling edge after that pulse, and it waits several cycles after every reset before driving anything. The bench memory answers each bus request with a one-cycle mem_ready one cycle later, and it never raises mem_ready without a pending request.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CMP  = 3'd1,
    ST_WB   = 3'd2,
    ST_FILL = 3'd3,
    ST_UNC  = 3'd4,
    ST_RESP = 3'd5
  } dc_state_e;
endpackage

// File: rtl/dc_rst_sync.sv
module dc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/dc_bypass.sv
module dc_bypass (
  input  logic addr_top,
  input  logic io_flag,
  input  logic flush,
  output logic bypass
);
  // Flush always consults the line store; otherwise top bit or I/O flag routes to the bus.
  assign bypass = !flush && (addr_top || io_flag);
endmodule

// File: rtl/dc_store.sv
module dc_store #(
  parameter int LINES = 64,
  parameter int WORDS = 8,
  parameter int TAG_W = 20,
  localparam int IDX_W  = $clog2(LINES),
  localparam int WOFF_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WOFF_W-1:0] woff,
  output logic [31:0]       rd_word,
  output logic [TAG_W-1:0]  rd_tag,
  output logic              rd_valid,
  output logic              rd_dirty,
  input  logic              wr_en,
  input  logic [3:0]        wr_be,
  input  logic [31:0]       wr_word,
  input  logic              meta_we,
  input  logic [TAG_W-1:0]  meta_tag,
  input  logic              meta_valid,
  input  logic              meta_dirty
);
  logic [31:0]      data_q [LINES*WORDS];
  logic [TAG_W-1:0] tag_q  [LINES];
  logic [LINES-1:0] valid_q, dirty_q;

  assign rd_word  = data_q[{idx, woff}];
  assign rd_tag   = tag_q[idx];
  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];

  for (genvar b = 0; b < 4; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr_en && wr_be[b]) data_q[{idx, woff}][8*b +: 8] <= wr_word[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (meta_we) tag_q[idx] <= meta_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (meta_we) begin
      valid_q[idx] <= meta_valid;
      dirty_q[idx] <= meta_dirty;
    end
  end
endmodule

// File: rtl/dc_front.sv
module dc_front #(
  parameter int LINE_BYTES = 32,
  parameter int LINES      = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic        cpu_io,
  input  logic        cpu_flush,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  input  logic [3:0]  cpu_be,
  output logic [31:0] cpu_rdata,
  output logic        cpu_done,
  output logic        cpu_busy,
  output logic        mem_req,
  output logic        mem_we,
  output logic [30:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ready
);
  import dc_pkg::*;

  localparam int WORDS  = LINE_BYTES / 4;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int WOFF_W = OFF_W - 2;
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = 31 - OFF_W - IDX_W;
  localparam logic [WOFF_W-1:0] LAST = WOFF_W'(WORDS - 1);

  logic rst_n_i, bypass, accept;
  dc_state_e state_q, state_d;
  logic [WOFF_W-1:0] cnt_q, cnt_d;
  logic [31:0] rdata_q, rdata_d;
  logic [30:2] r_addr;
  logic r_we, r_flush;
  logic [31:0] r_wdata;
  logic [3:0] r_be;
  logic unused_lsb;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag, st_tag;
  logic [WOFF_W-1:0] woff;
  logic [31:0] st_word, wr_word;
  logic st_valid, st_dirty, hit, wr_en, meta_we, meta_valid, meta_dirty;
  logic [3:0] wr_be;

  assign unused_lsb = ^cpu_addr[1:0];

  dc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  dc_bypass u_byp (.addr_top(cpu_addr[31]), .io_flag(cpu_io), .flush(cpu_flush), .bypass(bypass));

  assign idx  = r_addr[OFF_W +: IDX_W];
  assign tag  = r_addr[30 -: TAG_W];
  assign woff = (state_q == ST_WB || state_q == ST_FILL) ? cnt_q : r_addr[2 +: WOFF_W];
  assign hit  = st_valid && (st_tag == tag);

  dc_store #(.LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n_i), .idx(idx), .woff(woff),
    .rd_word(st_word), .rd_tag(st_tag), .rd_valid(st_valid), .rd_dirty(st_dirty),
    .wr_en(wr_en), .wr_be(wr_be), .wr_word(wr_word),
    .meta_we(meta_we), .meta_tag(tag), .meta_valid(meta_valid), .meta_dirty(meta_dirty)
  );

  assign accept = (state_q == ST_IDLE) && cpu_req;

  // Next-state and store-control process
  always_comb begin
    state_d = state_q;  cnt_d = cnt_q;  rdata_d = rdata_q;
    wr_en = 1'b0;  wr_be = r_be;  wr_word = r_wdata;
    meta_we = 1'b0;  meta_valid = 1'b0;  meta_dirty = 1'b0;
    unique case (state_q)
      ST_IDLE: if (cpu_req) state_d = bypass ? ST_UNC : ST_CMP;
      ST_CMP: begin
        cnt_d = '0;
        if (r_flush) begin
          if (hit && st_dirty) state_d = ST_WB;
          else begin
            meta_we = hit;
            state_d = ST_RESP;
          end
        end else if (hit) begin
          if (r_we) begin
            wr_en = 1'b1;  meta_we = 1'b1;  meta_valid = 1'b1;  meta_dirty = 1'b1;
          end else begin
            rdata_d = st_word;
          end
          state_d = ST_RESP;
        end else begin
          state_d = (st_valid && st_dirty) ? ST_WB : ST_FILL;
        end
      end
      ST_WB: if (mem_ready) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          if (r_flush) begin
            meta_we = 1'b1;
            state_d = ST_RESP;
          end else begin
            state_d = ST_FILL;
          end
        end
      end
      ST_FILL: if (mem_ready) begin
        wr_en = 1'b1;  wr_be = 4'hF;  wr_word = mem_rdata;
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          meta_we = 1'b1;  meta_valid = 1'b1;
          state_d = ST_CMP;
        end
      end
      ST_UNC: if (mem_ready) begin
        if (!r_we) rdata_d = mem_rdata;
        state_d = ST_RESP;
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rdata_q <= rdata_d;
    end
  end

  // Request capture, clock-enabled on acceptance
  always_ff @(posedge clk) begin
    if (accept) begin
      r_addr  <= cpu_addr[30:2];
      r_we    <= cpu_we;
      r_flush <= cpu_flush;
      r_wdata <= cpu_wdata;
      r_be    <= cpu_be;
    end
  end

  assign cpu_rdata = rdata_q;
  assign cpu_done  = (state_q == ST_RESP);
  assign cpu_busy  = (state_q != ST_IDLE);

  assign mem_req   = (state_q == ST_WB) || (state_q == ST_FILL) || (state_q == ST_UNC);
  assign mem_we    = (state_q == ST_WB) || ((state_q == ST_UNC) && r_we);
  assign mem_addr  = (state_q == ST_UNC) ? {r_addr, 2'b00}
                   : {((state_q == ST_WB) ? st_tag : tag), idx, cnt_q, 2'b00};
  assign mem_wdata = (state_q == ST_WB) ? st_word : r_wdata;
  assign mem_be    = ((state_q == ST_UNC) && r_we) ? r_be : 4'hF;
endmodule

// File: rtl/dc_front_chk.sv
module dc_front_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req,
  input logic        cpu_io,
  input logic        cpu_flush,
  input logic [31:0] cpu_addr,
  input logic        cpu_done,
  input logic        cpu_busy,
  input logic        mem_req,
  input logic        mem_we,
  input logic [30:0] mem_addr,
  input logic        mem_ready
);
  // R4: bypassed access reaches the bus right after acceptance
  p_unc_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_busy && !cpu_flush && (cpu_addr[31] || cpu_io)) |=> mem_req);

  // R4: no bus activity without a request in progress
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_busy |-> !mem_req);

  // R10: acceptance raises busy
  p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_busy) |=> cpu_busy);

  // R10: done is a single-cycle pulse inside busy with the bus idle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);
  p_done_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> (cpu_busy && !mem_req));

  // R10: pending bus request holds its address and direction
  p_bus_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind dc_front dc_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_io(cpu_io), .cpu_flush(cpu_flush),
  .cpu_addr(cpu_addr), .cpu_done(cpu_done), .cpu_busy(cpu_busy),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ready(mem_ready)
);

// File: tb/dc_front_test.sv
module dc_front_test;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 8192;

  typedef struct packed {
    logic [2:0]  op;     // 0 rd, 1 wr, 2 io rd, 3 io wr, 4 flush
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [3:0]  be;
    logic        chk;
    logic [31:0] exp;
    logic [3:0]  rq;
  } vec_t;

  function automatic logic [31:0] init_word(input int i);
    logic [15:0] v;
    v = 16'(i);
    return {v ^ 16'hA5C3, ~v};
  endfunction

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'h0000_0040, 32'h0, 4'hF, 1'b1, init_word(16), 4'd6},                    // R6 read miss fill
    '{3'd1, 32'h0000_0040, 32'h1122_3344, 4'hF, 1'b0, 32'h0, 4'd5},                    // R5 write hit
    '{3'd0, 32'h0000_0040, 32'h0, 4'hF, 1'b1, 32'h1122_3344, 4'd5},                    // R5 read hit
    '{3'd0, 32'h8000_0040, 32'h0, 4'hF, 1'b1, init_word(16), 4'd8},                    // R8 stale alias
    '{3'd4, 32'h0000_0040, 32'h0, 4'hF, 1'b0, 32'h0, 4'd7},                            // R7 flush
    '{3'd0, 32'h8000_0040, 32'h0, 4'hF, 1'b1, 32'h1122_3344, 4'd3},                    // R3 alias after flush
    '{3'd3, 32'h0000_0080, 32'hCAFE_F00D, 4'h3, 1'b0, 32'h0, 4'd9},                    // R9 io write lanes 0,1
    '{3'd0, 32'h8000_0080, 32'h0, 4'hF, 1'b1,
      (init_word(32) & 32'hFFFF_0000) | 32'h0000_F00D, 4'd9},                          // R9
    '{3'd1, 32'h8000_0100, 32'hDEAD_BEEF, 4'hF, 1'b0, 32'h0, 4'd1},                    // R1 uncached write
    '{3'd0, 32'h0000_0100, 32'h0, 4'hF, 1'b1, 32'hDEAD_BEEF, 4'd3},                    // R3 cached sees it
    '{3'd1, 32'h0000_0844, 32'h5566_7788, 4'hF, 1'b0, 32'h0, 4'd6},                    // R6 write allocate
    '{3'd0, 32'h0000_0044, 32'h0, 4'hF, 1'b1, init_word(17), 4'd6},                    // R6 dirty eviction
    '{3'd0, 32'h8000_0844, 32'h0, 4'hF, 1'b1, 32'h5566_7788, 4'd6},                    // R6 victim written
    '{3'd1, 32'h0000_0048, 32'hAABB_CCDD, 4'h4, 1'b0, 32'h0, 4'd9},                    // R9 lane 2 only
    '{3'd0, 32'h0000_0048, 32'h0, 4'hF, 1'b1,
      (init_word(18) & 32'hFF00_FFFF) | 32'h00BB_0000, 4'd9},                          // R9
    '{3'd2, 32'h0000_0048, 32'h0, 4'hF, 1'b1, init_word(18), 4'd2}                     // R2 io read bypass
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0, cpu_io = 1'b0, cpu_flush = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [3:0] cpu_be = '0;
  logic [31:0] cpu_rdata;
  logic cpu_done, cpu_busy, mem_req, mem_we;
  logic [30:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0] mem_be;
  logic [31:0] mem_rdata = '0;
  logic mem_ready = 1'b0;

  int checks = 0, fails = 0;
  int n_rd = 0, n_wr = 0, n_ops = 0, last_wr_stamp = 0;
  int busy_gap;
  logic first_mreq;
  logic [30:0] first_maddr;

  logic [31:0] mem_q [MEM_WORDS];
  logic [MEM_WORDS-1:0] mem_w = '0;

  dc_front uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_io(cpu_io),
    .cpu_flush(cpu_flush), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
    .cpu_rdata(cpu_rdata), .cpu_done(cpu_done), .cpu_busy(cpu_busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bus memory: answers one cycle after a request
  always @(posedge clk) begin
    if (mem_ready) begin
      mem_ready <= 1'b0;
    end else if (mem_req) begin
      automatic int w = int'(mem_addr[14:2]);
      automatic logic [31:0] cur = mem_w[w] ? mem_q[w] : init_word(w);
      if (mem_we) begin
        for (int b = 0; b < 4; b++) if (mem_be[b]) cur[8*b +: 8] = mem_wdata[8*b +: 8];
        mem_q[w] <= cur;
        mem_w[w] <= 1'b1;
        n_wr <= n_wr + 1;
        last_wr_stamp <= n_ops;
      end else begin
        mem_rdata <= cur;
        n_rd <= n_rd + 1;
      end
      n_ops <= n_ops + 1;
      mem_ready <= 1'b1;
    end
  end

  task automatic check(input string rq, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", rq, got, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [31:0] addr, input logic [31:0] wd,
                       input logic [3:0] be, output logic [31:0] rd);
    @(negedge clk);
    cpu_req = 1'b1;  cpu_we = (op == 3'd1 || op == 3'd3);  cpu_io = (op == 3'd2 || op == 3'd3);
    cpu_flush = (op == 3'd4);  cpu_addr = addr;  cpu_wdata = wd;  cpu_be = be;
    busy_gap = 0;
    @(negedge clk);
    first_mreq = mem_req;
    first_maddr = mem_addr;
    while (!cpu_done) begin
      if (!cpu_busy) busy_gap++;
      @(negedge clk);
    end
    if (!cpu_busy) busy_gap++;
    rd = cpu_rdata;
    cpu_req = 1'b0;  cpu_we = 1'b0;  cpu_io = 1'b0;  cpu_flush = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int b_rd, b_wr, b_ops;
    do_reset();
    // R11: idle outputs after reset
    check("R11 busy after reset", {31'b0, cpu_busy}, 32'd0);
    check("R11 done after reset", {31'b0, cpu_done}, 32'd0);
    check("R11 mem_req after reset", {31'b0, mem_req}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      do_op(VECS[i].op, VECS[i].addr, VECS[i].wdata, VECS[i].be, rd);
      if (VECS[i].chk) check($sformatf("R%0d vector %0d rdata", VECS[i].rq, i), rd, VECS[i].exp);
      check($sformatf("R10 vector %0d busy gap", i), busy_gap, 0);
    end

    // R5: hit makes no bus traffic
    b_rd = n_rd;  b_wr = n_wr;
    do_op(3'd0, 32'h0000_0048, 32'h0, 4'hF, rd);
    check("R5 hit bus transfers", n_rd + n_wr - b_rd - b_wr, 0);

    // R1: uncached read is one transfer and does not allocate
    b_rd = n_rd;
    do_op(3'd0, 32'h8000_0200, 32'h0, 4'hF, rd);
    check("R1 uncached read count", n_rd - b_rd, 1);
    check("R1 uncached read data", rd, init_word(128));
    b_rd = n_rd;
    do_op(3'd0, 32'h0000_0200, 32'h0, 4'hF, rd);
    check("R1 no allocation, later miss", n_rd - b_rd, 8);

    // R4 and R3: bus request in the first cycle, bit 31 stripped
    do_op(3'd0, 32'h8000_0304, 32'h0, 4'hF, rd);
    check("R4 mem_req after accept", {31'b0, first_mreq}, 32'd1);
    check("R3 mem_addr bit31 dropped", {1'b0, first_maddr}, 32'h0000_0304);

    // R7: flush of absent line, then of dirty line
    b_wr = n_wr;  b_rd = n_rd;
    do_op(3'd4, 32'h0000_3000, 32'h0, 4'hF, rd);
    check("R7 absent flush transfers", n_wr + n_rd - b_wr - b_rd, 0);
    do_op(3'd1, 32'h0000_0060, 32'h0BAD_CAFE, 4'hF, rd);
    b_wr = n_wr;
    do_op(3'd4, 32'h8000_0064, 32'h0, 4'hF, rd);
    check("R7 dirty flush writes", n_wr - b_wr, 8);
    check("R10 flush busy gap", busy_gap, 0);
    b_rd = n_rd;
    do_op(3'd0, 32'h0000_0060, 32'h0, 4'hF, rd);
    check("R7 flushed line misses", n_rd - b_rd, 8);
    check("R7 flushed data kept", rd, 32'h0BAD_CAFE);

    // R6: victim write-back precedes refill
    do_op(3'd1, 32'h0000_0090, 32'h7777_0001, 4'hF, rd);
    b_rd = n_rd;  b_wr = n_wr;  b_ops = n_ops;
    do_op(3'd0, 32'h0000_0890, 32'h0, 4'hF, rd);
    check("R6 eviction writes", n_wr - b_wr, 8);
    check("R6 refill reads", n_rd - b_rd, 8);
    check("R6 last write before reads", last_wr_stamp, b_ops + 7);

    // R11: reset drops dirty state
    do_op(3'd1, 32'h0000_00A0, 32'h1234_5678, 4'hF, rd);
    do_reset();
    check("R11 busy after mid reset", {31'b0, cpu_busy}, 32'd0);
    check("R11 mem_req after mid reset", {31'b0, mem_req}, 32'd0);
    b_rd = n_rd;  b_wr = n_wr;
    do_op(3'd0, 32'h0000_00A0, 32'h0, 4'hF, rd);
    check("R11 line invalid after reset", n_rd - b_rd, 8);
    check("R11 dirty data not written", n_wr - b_wr, 0);
    check("R11 read memory value", rd, init_word(40));

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule